// File: doc/BRIEF.md
# Dual-Bank Simultaneous-Sampling Converter Interface Model

This block stands in for a two-converter, simultaneous-sampling 12-bit ADC on an FPGA test board. It presents the converter's digital side to the logic under test: an active-low start strobe, chip select, read strobe and bank select come in, and a busy line and a 12-bit data word with its output enable go out. Four 12-bit sample inputs take the place of the analog inputs. They are arranged as bank A (A1, A2) and bank B (B1, B2).

A falling edge on the start strobe freezes both samples of the selected bank and begins a timed conversion. When busy drops, two reads return the pair in a fixed order. In auto-sleep mode the model goes to sleep if the strobe is still low when a conversion ends. The next rising edge of the strobe starts a wake-up delay, and that delay lengthens the following conversion. The model raises a sticky timing flag when a read overlaps a conversion or ends too close to the next start. All durations are given in nanoseconds and converted to clock cycles from a clock-period parameter.

Top module: `sim_adc_emu`

## Requirements
- R1: After reset, busy is 0, the data output enable is 0 and the timing flag is 0.
- R2: A falling edge of `conv_n` seen while idle latches both samples of the bank given by `bank_sel` (0 = bank A, 1 = bank B) and sets busy from the next clock edge.
- R3: While awake, busy stays high for exactly CONV_CYC cycles, which is 360 at the default parameters.
- R4: After a start, the first completed read returns input 1 of the latched bank and the second returns input 2. A third read returns input 1 again. Each new start resets the order to input 1.
- R5: `data_oe` is 1 exactly while `cs_n` and `rd_n` are both low. Chip select alone does not enable the bus.
- R6: Changes to the sample inputs or to `bank_sel` after the start edge do not alter the results that are read.
- R7: With `auto_sleep` = 1 and `conv_n` low when busy drops, the model sleeps. The next conversion then ends WAKE_CYC + CONV_CYC cycles after the strobe's rising edge, provided the falling edge arrives inside the wake-up window.
- R8: When asleep, if the strobe stays high for longer than WAKE_CYC, busy lasts CONV_CYC cycles from the falling edge.
- R9: With `auto_sleep` = 0, holding `conv_n` low at the end of a conversion does not cause sleep, and the next conversion lasts CONV_CYC.
- R10: Reads made while asleep return the latched results in the R4 order.
- R11: A read active while busy is high sets `timing_err`. Once set, the flag stays set until reset.
- R12: An accepted start that comes fewer than SETTLE_CYC cycles after the end of a read sets `timing_err`. A start that comes later does not set it.
- R13: A falling edge of `conv_n` during busy is ignored. It neither restarts the timer nor relatches the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Start strobe, active low, sampled on its falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| bank_sel | input | 1 | Bank choice at start: 0 = A, 1 = B |
| auto_sleep | input | 1 | 1 selects auto-sleep mode |
| smp_a1 | input | 12 | Bank A input 1 value |
| smp_a2 | input | 12 | Bank A input 2 value |
| smp_b1 | input | 12 | Bank B input 1 value |
| smp_b2 | input | 12 | Bank B input 2 value |
| busy | output | 1 | High while a conversion runs |
| data_out | output | 12 | Result word, valid while data_oe is high |
| data_oe | output | 1 | Output enable for the tri-state pad |
| timing_err | output | 1 | Sticky read-timing violation flag |

## Verification
The bench builds the block with its default parameters: a 10 ns clock, a 3600 ns conversion, a 2500 ns wake-up and a 300 ns settling window. These give 360, 250 and 30 cycles. Because the wake-up is shorter than the conversion, the bench can test a start that falls inside the wake-up window (expecting 600 busy cycles) and a start that falls after it (expecting 360). The 30-cycle window leaves room to test read-to-start gaps of 5 and 40 cycles, one on each side of the limit. The run stays within a few thousand cycles.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    localparam int SMP_W = 12;

    typedef enum logic [1:0] {
        PWR_AWAKE  = 2'd0,
        PWR_ASLEEP = 2'd1,
        PWR_WAKING = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic [SMP_W-1:0] first;
        logic [SMP_W-1:0] second;
    } sample_pair_t;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/adc_emu_conv_ctrl.sv
module adc_emu_conv_ctrl
    import adc_emu_pkg::*;
#(
    parameter int CONV_CYC = 360,
    parameter int WAKE_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_lvl,
    input  logic strobe_rise,
    input  logic strobe_fall,
    input  logic auto_sleep,
    output logic start,
    output logic busy
);
    localparam int CW = $clog2(CONV_CYC + 1);
    localparam int WW = $clog2(WAKE_CYC + 1);

    pwr_state_e    state_q;
    logic [CW-1:0] conv_cnt_q;
    logic [WW-1:0] wake_cnt_q;

    // a start edge counts only when no conversion is running
    assign start = strobe_fall & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PWR_AWAKE;
            busy       <= 1'b0;
            conv_cnt_q <= '0;
            wake_cnt_q <= '0;
        end else begin
            case (state_q)
                PWR_ASLEEP: begin
                    if (strobe_rise) begin
                        state_q    <= PWR_WAKING;
                        wake_cnt_q <= '0;
                    end
                end
                PWR_WAKING: begin
                    if (wake_cnt_q == WW'(WAKE_CYC - 1)) state_q <= PWR_AWAKE;
                    else                                  wake_cnt_q <= wake_cnt_q + 1'b1;
                end
                default: ;
            endcase

            if (start) begin
                busy       <= 1'b1;
                conv_cnt_q <= '0;
            end else if (busy && state_q == PWR_AWAKE) begin
                if (conv_cnt_q == CW'(CONV_CYC - 1)) begin
                    busy <= 1'b0;
                    if (auto_sleep && !strobe_lvl) state_q <= PWR_ASLEEP;
                end else begin
                    conv_cnt_q <= conv_cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_emu_read_port.sv
module adc_emu_read_port
    import adc_emu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bank_sel,
    input  logic [SMP_W-1:0] smp_a1,
    input  logic [SMP_W-1:0] smp_a2,
    input  logic [SMP_W-1:0] smp_b1,
    input  logic [SMP_W-1:0] smp_b2,
    input  logic             rd_active,
    input  logic             read_end,
    output logic [SMP_W-1:0] data_out,
    output logic             data_oe
);
    sample_pair_t bank_pair [2];
    sample_pair_t held_q;
    logic         ptr_q;

    assign bank_pair[0] = '{first: smp_a1, second: smp_a2};
    assign bank_pair[1] = '{first: smp_b1, second: smp_b2};

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            ptr_q  <= 1'b0;
        end else if (start) begin
            held_q <= bank_pair[bank_sel];
            ptr_q  <= 1'b0;
        end else if (read_end) begin
            ptr_q  <= ~ptr_q;
        end
    end

    assign data_oe  = rd_active;
    assign data_out = ptr_q ? held_q.second : held_q.first;
endmodule

// File: rtl/adc_emu_guard.sv
module adc_emu_guard #(
    parameter int SETTLE_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic rd_active,
    input  logic start,
    output logic timing_err
);
    localparam int GW = $clog2(SETTLE_CYC + 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q      <= GW'(SETTLE_CYC);
            timing_err <= 1'b0;
        end else begin
            if (rd_active)                   gap_q <= '0;
            else if (gap_q != GW'(SETTLE_CYC)) gap_q <= gap_q + 1'b1;

            if ((rd_active && busy) || (start && gap_q < GW'(SETTLE_CYC)))
                timing_err <= 1'b1;
        end
    end
endmodule

// File: rtl/sim_adc_emu.sv
module sim_adc_emu
    import adc_emu_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int CONV_NS       = 3600,
    parameter int WAKE_NS       = 2500,
    parameter int SETTLE_NS     = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             bank_sel,
    input  logic             auto_sleep,
    input  logic [SMP_W-1:0] smp_a1,
    input  logic [SMP_W-1:0] smp_a2,
    input  logic [SMP_W-1:0] smp_b1,
    input  logic [SMP_W-1:0] smp_b2,
    output logic             busy,
    output logic [SMP_W-1:0] data_out,
    output logic             data_oe,
    output logic             timing_err
);
    localparam int CONV_CYC   = ns_to_cycles(CONV_NS, CLK_PERIOD_NS);
    localparam int WAKE_CYC   = ns_to_cycles(WAKE_NS, CLK_PERIOD_NS);
    localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_NS);

    logic strobe_rise, strobe_fall;
    logic rd_active, rd_begin, read_end;
    logic start;

    assign rd_active = ~cs_n & ~rd_n;

    adc_emu_edge #(.RST_VAL(1'b1)) strobe_edge_i (
        .clk(clk), .rst(rst), .sig(conv_n),
        .rise(strobe_rise), .fall(strobe_fall)
    );

    adc_emu_edge #(.RST_VAL(1'b0)) read_edge_i (
        .clk(clk), .rst(rst), .sig(rd_active),
        .rise(rd_begin), .fall(read_end)
    );

    adc_emu_conv_ctrl #(.CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC)) ctrl_i (
        .clk(clk), .rst(rst), .strobe_lvl(conv_n),
        .strobe_rise(strobe_rise), .strobe_fall(strobe_fall),
        .auto_sleep(auto_sleep), .start(start), .busy(busy)
    );

    adc_emu_read_port rport_i (
        .clk(clk), .rst(rst), .start(start), .bank_sel(bank_sel),
        .smp_a1(smp_a1), .smp_a2(smp_a2), .smp_b1(smp_b1), .smp_b2(smp_b2),
        .rd_active(rd_active), .read_end(read_end),
        .data_out(data_out), .data_oe(data_oe)
    );

    adc_emu_guard #(.SETTLE_CYC(SETTLE_CYC)) guard_i (
        .clk(clk), .rst(rst), .busy(busy), .rd_active(rd_active),
        .start(start), .timing_err(timing_err)
    );

    logic unused_rd_begin;
    assign unused_rd_begin = rd_begin;
endmodule

// File: rtl/sim_adc_emu_chk.sv
module sim_adc_emu_chk #(
    parameter int CONV_CYC = 360,
    parameter int WAKE_CYC = 250
) (
    input logic clk,
    input logic rst,
    input logic conv_n,
    input logic cs_n,
    input logic rd_n,
    input logic busy,
    input logic data_oe,
    input logic timing_err
);
    localparam int LW = $clog2(CONV_CYC + WAKE_CYC + 2);

    logic          conv_prev_q;
    logic [LW-1:0] busy_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_prev_q <= 1'b1;
            busy_len_q  <= '0;
        end else begin
            conv_prev_q <= conv_n;
            busy_len_q  <= busy ? busy_len_q + 1'b1 : '0;
        end
    end

    // R5
    oe_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe == (!cs_n && !rd_n));

    // R11
    busy_read_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_n && !rd_n) |=> timing_err);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        timing_err |=> timing_err);

    // R2
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_prev_q && !conv_n && !busy) |=> busy);

    // R3
    busy_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len_q >= LW'(CONV_CYC)));

    // R7
    busy_max_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_len_q <= LW'(CONV_CYC + WAKE_CYC));
endmodule

bind sim_adc_emu sim_adc_emu_chk #(.CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC)) chk_i (
    .clk(clk), .rst(rst), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
    .busy(busy), .data_oe(data_oe), .timing_err(timing_err)
);

// File: tb/sim_adc_emu_tb_top.sv
module sim_adc_emu_tb_top;
    localparam int CONV = 360;
    localparam int WAKE = 250;

    logic        clk = 1'b0;
    logic        rst, conv_n, cs_n, rd_n, bank_sel, auto_sleep;
    logic [11:0] smp_a1, smp_a2, smp_b1, smp_b2;
    logic        busy, data_oe, timing_err;
    logic [11:0] data_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sim_adc_emu dut_i (
        .clk(clk), .rst(rst), .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n),
        .bank_sel(bank_sel), .auto_sleep(auto_sleep),
        .smp_a1(smp_a1), .smp_a2(smp_a2), .smp_b1(smp_b1), .smp_b2(smp_b2),
        .busy(busy), .data_out(data_out), .data_oe(data_oe), .timing_err(timing_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; conv_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        bank_sel = 1'b0; auto_sleep = 1'b0;
        smp_a1 = 12'h123; smp_a2 = 12'hABC; smp_b1 = 12'h456; smp_b2 = 12'h789;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive the strobe low now and count busy cycles until it drops
    task automatic start_measure(output int n);
        conv_n = 1'b0;
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
    endtask

    task automatic read_word(output logic [11:0] d, output logic oe);
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        d = data_out; oe = data_oe;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 busy", busy, 0);
        check("R1 oe", data_oe, 0);
        check("R1 flag", timing_err, 0);
    endtask

    task automatic t_basic();
        int n; logic [11:0] d; logic oe;
        do_reset();
        conv_n = 1'b0;
        @(negedge clk);
        check("R2 busy after start", busy, 1);
        // R6: disturb everything after the start edge
        bank_sel = 1'b1; smp_a1 = 12'h001; smp_a2 = 12'h002;
        n = 1;
        while (busy && n < 2000) begin @(negedge clk); if (busy) n++; end
        check("R3 awake busy length", n, CONV);
        wait_cyc(5);
        check("R5 idle oe", data_oe, 0);
        cs_n = 1'b0; @(negedge clk);
        check("R5 cs only oe", data_oe, 0);
        cs_n = 1'b1; @(negedge clk);
        read_word(d, oe);
        check("R5 oe during read", oe, 1);
        check("R4 R6 first read A1", d, 12'h123);
        read_word(d, oe);
        check("R4 R6 second read A2", d, 12'hABC);
        read_word(d, oe);
        check("R4 third read A1 again", d, 12'h123);
        // bank B conversion, pointer must restart
        conv_n = 1'b1; wait_cyc(40);
        start_measure(n);
        check("R3 bank B busy length", n, CONV);
        read_word(d, oe);
        check("R2 R4 first read B1", d, 12'h456);
        read_word(d, oe);
        check("R2 second read B2", d, 12'h789);
        check("R12 no flag with long gaps", timing_err, 0);
    endtask

    task automatic t_ignore_restart();
        int n; logic [11:0] d; logic oe;
        do_reset();
        conv_n = 1'b0;
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
            if (i == 20) conv_n = 1'b1;
            if (i == 30) begin conv_n = 1'b0; smp_a1 = 12'hF0F; end
        end
        check("R13 busy not restarted", n, CONV);
        read_word(d, oe);
        check("R13 sample not relatched", d, 12'h123);
    endtask

    task automatic t_busy_read();
        logic [11:0] d; logic oe; int n;
        do_reset();
        conv_n = 1'b0;
        wait_cyc(50);
        check("R11 flag before read", timing_err, 0);
        read_word(d, oe);
        check("R11 flag after busy read", timing_err, 1);
        n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        wait_cyc(40);
        check("R11 flag sticky", timing_err, 1);
    endtask

    task automatic t_settle(input int gap, input int exp_flag);
        int n; logic [11:0] d; logic oe;
        do_reset();
        start_measure(n);
        conv_n = 1'b1;
        read_word(d, oe);
        wait_cyc(gap);
        conv_n = 1'b0;
        wait_cyc(3);
        check($sformatf("R12 flag gap %0d", gap), timing_err, exp_flag);
    endtask

    task automatic t_sleep();
        int n; logic [11:0] d; logic oe;
        do_reset();
        auto_sleep = 1'b1;
        start_measure(n);
        check("R3 first conversion awake", n, CONV);
        read_word(d, oe);
        check("R10 read while asleep A1", d, 12'h123);
        read_word(d, oe);
        check("R10 read while asleep A2", d, 12'hABC);
        wait_cyc(40);
        conv_n = 1'b1; wait_cyc(10);
        start_measure(n);
        check("R7 wake plus conversion", n, WAKE + CONV - 10);
        wait_cyc(40);
        conv_n = 1'b1; wait_cyc(300);
        start_measure(n);
        check("R8 long strobe high", n, CONV);
        check("R7 no flag", timing_err, 0);
    endtask

    task automatic t_mode1();
        int n;
        do_reset();
        auto_sleep = 1'b0;
        start_measure(n);
        wait_cyc(40);
        conv_n = 1'b1; wait_cyc(10);
        start_measure(n);
        check("R9 no sleep in mode 1", n, CONV);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_ignore_restart();
        t_busy_read();
        t_settle(5, 1);
        t_settle(40, 0);
        t_sleep();
        t_mode1();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule